// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This block is one channel of a general-purpose timer, packaged with the free-running up-counter it watches. The counter climbs from zero to a programmable modulus, returns to zero, and raises an overflow strobe in that wrap cycle. A hold bit parks the counter at zero so that software can change the channel mode safely.

A small register port configures the channel. Each write and each read completes in a single cycle. There is no back-pressure: every access is accepted in the cycle it is presented, and read data is combinational from the read address. A single mode/edge code picks what the channel does:

- **Pin preset:** the channel lets go of the pin and holds a preset level.
- **Input capture:** on a selected edge of a synchronised input, it latches the counter value.
- **Output compare:** on a counter match, it toggles, clears or sets the pin.

An optional toggle-on-overflow overrides any compare action that lands in the same cycle. A sticky flag records captures and matches. Software clears it by reading the flag while it is set and then writing a zero to it.

Top module: `tmr_chan_top`

Register map (3-bit address):

| Address | Register | Contents |
|---|---|---|
| 0 | Control | bit0 = hold |
| 1 | Modulus | modulus value |
| 2 | Config | bit0 = tov, bit1 = elA, bit2 = elB, bit3 = msA, bit4 = msB, bit5 = flag |
| 3 | Channel value | compare or captured value |
| 4 | Counter | read only |

The 2-bit code el is {elB, elA}. Output mode means msB or msA is set.

## Requirements
- R1: The counter reads 0, 1, …, M, 0, … where M is the modulus register (address 1). The `tmr_ovf` output is 1 exactly in the cycle the counter equals M while not held.
- R2: While the hold bit (address 0, bit0) is 1, the counter reads 0 and `tmr_ovf` stays 0. After hold is cleared by a write, the counter reads k after k further clock edges.
- R3: When el = 00, `ch_oe` is 0 and `ch_out` becomes the inverse of msA one cycle later (msA=1 gives low, msA=0 gives high).
- R4: In capture mode (msB=msA=0), `cap_in` passes through two flip-flops. el = 01 captures on rising edges only, 10 on falling edges only, and 11 on both. The channel value (address 3) takes the counter value of the cycle in which the synchronised edge is seen, and the flag (config bit5) sets. With the default two stages, a change of `cap_in` before clock edge S whose counter value is j after S captures the value j+1.
- R5: In output mode, a counter match with the channel value while not held sets the flag one cycle later. With el = 00, `ch_oe` stays 0 and the pin is untouched.
- R6: In output mode with el = 01, 10 or 11, a match respectively toggles, clears or sets `ch_out`, effective one cycle after the match cycle. In these modes `ch_oe` is 1.
- R7: With tov (config bit0) = 1 in output mode with el ≠ 00, `ch_out` toggles one cycle after each overflow. In capture mode, tov has no effect and `ch_out` holds.
- R8: If tov = 1 and an overflow coincides with a match, the pin toggles and that cycle's compare action is dropped.
- R9: The flag stays set until cleared. A write to the config register with bit5 = 0 clears it only if the config register was read (`rd_en`) while the flag was 1 since the last config write. A capture or match in the same cycle keeps the flag set.
- R10: Reset clears hold, tov, el, msA, msB, the flag and the channel value, sets the modulus to all ones, and leaves `ch_out` = 1, `ch_oe` = 0.
- R11: msB = 1 selects compare behaviour identical to msA = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | W | Write data |
| rd_en | input | 1 | Read strobe (arms the flag clear) |
| rd_addr | input | 3 | Read address |
| rd_data | output | W | Combinational read data |
| cap_in | input | 1 | Asynchronous capture input |
| ch_out | output | 1 | Channel pin level |
| ch_oe | output | 1 | Channel owns the pin when 1 |
| tmr_ovf | output | 1 | Counter wrap strobe |

## Verification
Two behaviours can fall in the same cycle: the counter wrap with toggle-on-overflow, and a compare match. A directed case sets the channel value equal to the modulus with the set action. It starts the pin high, so a toggle and a set lead to different levels, and it checks that the pin goes low. Constrained random runs keep the modulus and channel value below 16, so coincidences, captures racing register writes, and events racing flag clears recur often. Every cycle is judged against a bench reference model.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int AW = 3;
  localparam logic [AW-1:0] A_CTRL = 3'd0;
  localparam logic [AW-1:0] A_MOD  = 3'd1;
  localparam logic [AW-1:0] A_CFG  = 3'd2;
  localparam logic [AW-1:0] A_CHV  = 3'd3;
  localparam logic [AW-1:0] A_CNT  = 3'd4;

  localparam int B_TOV = 0;
  localparam int B_ELA = 1;
  localparam int B_ELB = 2;
  localparam int B_MSA = 3;
  localparam int B_MSB = 4;
  localparam int B_FLG = 5;

  // compare action selected by the edge/level code in output mode
  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_TOGGLE = 2'b01,
    ACT_CLEAR  = 2'b10,
    ACT_SET    = 2'b11
  } pin_act_e;

  typedef struct packed {
    logic       msb;
    logic       msa;
    logic [1:0] el;
    logic       tov;
  } chcfg_t;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold,
  input  logic [W-1:0] mod_val,
  output logic [W-1:0] cnt,
  output logic         ovf
);
  // wrap strobe: last count of the period, only while running
  assign ovf = !hold && (cnt == mod_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (hold || ovf) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tmr_cap_detect.sv
module tmr_cap_detect #(
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cap_in,
  input  logic       enable,
  input  logic [1:0] el,
  output logic       hit
);
  logic [SYNC-1:0] stage_q;
  logic            prev_q;
  logic            rise, fall;

  for (genvar g = 0; g < SYNC; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= 1'b0;
        else        stage_q[0] <= cap_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= 1'b0;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= stage_q[SYNC-1];
  end

  assign rise = stage_q[SYNC-1] & ~prev_q;
  assign fall = ~stage_q[SYNC-1] & prev_q;
  // code bit0 arms rising edges, bit1 arms falling edges
  assign hit  = enable && ((el[0] && rise) || (el[1] && fall));
endmodule

// File: rtl/tmr_pin_ctrl.sv
module tmr_pin_ctrl
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] el,
  input  logic       msa,
  input  logic       out_mode,
  input  logic       tov,
  input  logic       ovf,
  input  logic       match,
  output logic       pin
);
  pin_act_e act;
  assign act = pin_act_e'(el);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin <= 1'b1;
    end else if (el == 2'b00) begin
      pin <= ~msa;                     // preset level under port control
    end else if (out_mode) begin
      if (tov && ovf) begin
        pin <= ~pin;                   // overflow toggle beats compare
      end else if (match) begin
        case (act)
          ACT_TOGGLE: pin <= ~pin;
          ACT_CLEAR:  pin <= 1'b0;
          ACT_SET:    pin <= 1'b1;
          default:    pin <= pin;
        endcase
      end
    end
  end
endmodule

// File: rtl/tmr_chan_top.sv
module tmr_chan_top
  import tmr_pkg::*;
#(
  parameter int W    = 16,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  input  logic [2:0]    rd_addr,
  output logic [W-1:0]  rd_data,
  input  logic          cap_in,
  output logic          ch_out,
  output logic          ch_oe,
  output logic          tmr_ovf
);
  localparam int CFGW = B_FLG + 1;

  logic         hold_q;
  logic [W-1:0] mod_q;
  chcfg_t       cfg;
  logic         flag_q;
  logic         armed_q;
  logic [W-1:0] chv_q;
  logic [W-1:0] cnt;
  logic         ovf;
  logic         out_mode;
  logic         match;
  logic         cap_hit;
  logic         pin;
  logic         cfg_wr;
  logic         flag_clr;

  assign cfg_wr   = wr_en && (wr_addr == A_CFG);
  assign flag_clr = cfg_wr && !wr_data[B_FLG] && armed_q;
  assign out_mode = cfg.msb | cfg.msa;
  assign match    = out_mode && !hold_q && (cnt == chv_q);

  tmr_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .hold(hold_q), .mod_val(mod_q),
    .cnt(cnt), .ovf(ovf)
  );

  tmr_cap_detect #(.SYNC(SYNC)) u_cap (
    .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .enable(!out_mode),
    .el(cfg.el), .hit(cap_hit)
  );

  tmr_pin_ctrl u_pin (
    .clk(clk), .rst_n(rst_n), .el(cfg.el), .msa(cfg.msa),
    .out_mode(out_mode), .tov(cfg.tov), .ovf(ovf), .match(match),
    .pin(pin)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      mod_q  <= '1;
      cfg    <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: hold_q <= wr_data[0];
        A_MOD:  mod_q  <= wr_data;
        A_CFG:  cfg    <= '{msb: wr_data[B_MSB], msa: wr_data[B_MSA],
                            el: {wr_data[B_ELB], wr_data[B_ELA]},
                            tov: wr_data[B_TOV]};
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (match || cap_hit) flag_q <= 1'b1;
      else if (flag_clr)    flag_q <= 1'b0;
      if (cfg_wr)                                   armed_q <= 1'b0;
      else if (rd_en && rd_addr == A_CFG && flag_q) armed_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          chv_q <= '0;
    else if (cap_hit)                    chv_q <= cnt;
    else if (wr_en && wr_addr == A_CHV)  chv_q <= wr_data;
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL: rd_data[0] = hold_q;
      A_MOD:  rd_data = mod_q;
      A_CFG:  rd_data[CFGW-1:0] = {flag_q, cfg.msb, cfg.msa, cfg.el, cfg.tov};
      A_CHV:  rd_data = chv_q;
      A_CNT:  rd_data = cnt;
      default: rd_data = '0;
    endcase
  end

  assign ch_out  = pin;
  assign ch_oe   = out_mode && (cfg.el != 2'b00);
  assign tmr_ovf = ovf;
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         hold_q,
  input logic [W-1:0] cnt,
  input logic [W-1:0] mod_q,
  input logic         ovf,
  input logic [1:0]   el,
  input logic         msa,
  input logic         out_mode,
  input logic         tov,
  input logic         match,
  input logic         flag,
  input logic         cfg_clr,
  input logic         ch_out
);
  AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |=> (cnt == '0)); // R2
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_q && cnt == mod_q) |=> (cnt == '0)); // R1
  AST_PRESET_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (el == 2'b00) |=> (ch_out == !$past(msa))); // R3
  AST_TOV_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_mode && el != 2'b00 && tov && ovf) |=> (ch_out != $past(ch_out))); // R8
  AST_CAP_PIN_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_mode && el != 2'b00) |=> (ch_out == $past(ch_out))); // R7
  AST_MATCH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> flag); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !cfg_clr) |=> flag); // R9
endmodule

bind tmr_chan_top tmr_chan_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hold_q(hold_q), .cnt(cnt), .mod_q(mod_q),
  .ovf(ovf), .el(cfg.el), .msa(cfg.msa), .out_mode(out_mode), .tov(cfg.tov),
  .match(match), .flag(flag_q),
  .cfg_clr(wr_en && wr_addr == tmr_pkg::A_CFG && !wr_data[tmr_pkg::B_FLG]),
  .ch_out(ch_out)
);

// File: tb/tmr_chan_top_tb_top.sv
module tmr_chan_top_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic         rd_en = 1'b0;
  logic [2:0]   rd_addr = '0;
  logic [W-1:0] rd_data;
  logic         cap_in = 1'b0;
  logic         ch_out, ch_oe, tmr_ovf;

  int checks = 0;
  int errors = 0;
  bit lock_en = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  tmr_chan_top #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .cap_in(cap_in), .ch_out(ch_out), .ch_oe(ch_oe), .tmr_ovf(tmr_ovf)
  );

  // ---------------- reference model built from the requirements
  logic         m_hold, m_tov, m_msa, m_msb, m_pin, m_flag, m_armed;
  logic [1:0]   m_el;
  logic [W-1:0] m_mod, m_cnt, m_chv;
  logic         m_s1, m_s2, m_prev;

  function automatic logic m_outm();
    return m_msb | m_msa;
  endfunction
  function automatic logic m_ovf();
    return !m_hold && (m_cnt == m_mod);
  endfunction
  function automatic logic [W-1:0] m_rd(input logic [2:0] a);
    case (a)
      3'd0: return {{(W-1){1'b0}}, m_hold};
      3'd1: return m_mod;
      3'd2: return {{(W-6){1'b0}}, m_flag, m_msb, m_msa, m_el, m_tov};
      3'd3: return m_chv;
      3'd4: return m_cnt;
      default: return '0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_hold = 0; m_tov = 0; m_msa = 0; m_msb = 0; m_el = 0;
      m_pin = 1; m_flag = 0; m_armed = 0; m_mod = '1; m_cnt = '0;
      m_chv = '0; m_s1 = 0; m_s2 = 0; m_prev = 0;
    end else begin
      automatic logic ov  = m_ovf();
      automatic logic om  = m_outm();
      automatic logic mt  = om && !m_hold && (m_cnt == m_chv);
      automatic logic ri  = m_s2 & ~m_prev;
      automatic logic fa  = ~m_s2 & m_prev;
      automatic logic cap = !om && ((m_el == 2'b01 && ri) || (m_el == 2'b10 && fa)
                                    || (m_el == 2'b11 && (ri || fa)));
      automatic logic cw  = wr_en && wr_addr == 3'd2;
      if (m_el == 2'b00) m_pin = ~m_msa;
      else if (om) begin
        if (m_tov && ov) m_pin = ~m_pin;
        else if (mt) begin
          if (m_el == 2'b01) m_pin = ~m_pin;
          else if (m_el == 2'b10) m_pin = 1'b0;
          else m_pin = 1'b1;
        end
      end
      if (mt || cap) m_flag = 1;
      else if (cw && !wr_data[5] && m_armed) m_flag = 0;
      if (cw) m_armed = 0;
      else if (rd_en && rd_addr == 3'd2 && m_flag) m_armed = 1;
      if (cap) m_chv = m_cnt;
      else if (wr_en && wr_addr == 3'd3) m_chv = wr_data;
      m_cnt = (m_hold || ov) ? '0 : m_cnt + 1'b1;
      if (wr_en) begin
        case (wr_addr)
          3'd0: m_hold = wr_data[0];
          3'd1: m_mod = wr_data;
          3'd2: begin m_tov = wr_data[0]; m_el = wr_data[2:1];
                      m_msa = wr_data[3]; m_msb = wr_data[4]; end
          default: ;
        endcase
      end
      m_prev = m_s2; m_s2 = m_s1; m_s1 = cap_in;
    end
  end

  // lockstep comparison every cycle, away from the active edge
  always @(negedge clk) begin
    if (lock_en && !done) begin
      checks++;
      if (ch_out !== m_pin || ch_oe !== (m_outm() && m_el != 2'b00) ||
          tmr_ovf !== m_ovf() || rd_data !== m_rd(rd_addr)) begin
        errors++;
        $display("FAIL R6/R9 lockstep t=%0t out=%b exp=%b oe=%b exp=%b ovf=%b exp=%b rd=%h exp=%h",
                 $time, ch_out, m_pin, ch_oe, (m_outm() && m_el != 2'b00),
                 tmr_ovf, m_ovf(), rd_data, m_rd(rd_addr));
      end
    end
  end

  // ---------------- helpers
  task automatic step();
    @(posedge clk); #5;
  endtask
  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    step();
    wr_en = 0;
  endtask
  task automatic peek(input logic [2:0] a, output logic [W-1:0] v);
    rd_addr = a; #1; v = rd_data;
  endtask
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [W-1:0] v;
    logic keep;
    void'($urandom(32'd20240607));
    repeat (3) @(posedge clk);
    #5 rst_n = 1;
    lock_en = 1;
    step();

    // R10: reset state
    peek(3'd2, v); chk("R10 cfg", v, 0);
    peek(3'd0, v); chk("R10 hold", v, 0);
    peek(3'd1, v); chk("R10 mod", v, 16'hFFFF);
    chk("R10 pin", {ch_oe, ch_out}, 2'b01);

    // R2: hold keeps the counter at zero
    wr(3'd0, 1);
    step(); step();
    peek(3'd4, v); chk("R2 held", v, 0);
    chk("R2 no ovf", tmr_ovf, 0);

    // R1: count 0..5 and wrap
    wr(3'd1, 5);
    wr(3'd0, 0);
    for (int k = 0; k < 14; k++) begin
      peek(3'd4, v); chk("R1 count", v, k % 6);
      chk("R1 ovf", tmr_ovf, (k % 6) == 5);
      step();
    end

    // R4: rising capture with exact value, falling edge ignored
    wr(3'd0, 1);
    wr(3'd1, 1000);
    wr(3'd2, 16'h02);
    wr(3'd0, 0);            // counter 0 now
    step(); step(); step(); // counter 3
    cap_in = 1;             // next edge is the fourth -> capture 5
    repeat (4) step();
    peek(3'd3, v); chk("R4 rising value", v, 5);
    peek(3'd2, v); chk("R4 flag", v[5], 1);
    cap_in = 0;
    repeat (4) step();
    peek(3'd3, v); chk("R4 falling ignored", v, 5);

    // R9: unarmed clear does nothing, read then write 0 clears
    wr(3'd2, 16'h02);
    peek(3'd2, v); chk("R9 unarmed keeps flag", v[5], 1);
    rd_en = 1; rd_addr = 3'd2; step(); rd_en = 0;
    wr(3'd2, 16'h02);
    peek(3'd2, v); chk("R9 armed clear", v[5], 0);

    // R8 and R11: overflow toggle wins over a coincident set
    wr(3'd0, 1);
    wr(3'd1, 7);
    wr(3'd3, 7);
    wr(3'd2, 16'h10);        // msB only, el 00 -> preset high
    chk("R3 preset high", {ch_oe, ch_out}, 2'b01);
    wr(3'd2, 16'h17);        // el 11 set, tov on
    wr(3'd0, 0);
    repeat (7) step();
    chk("R8 before wrap pin", ch_out, 1);
    chk("R8 wrap ovf", tmr_ovf, 1);
    step();
    chk("R8 toggle beats set", ch_out, 0);
    peek(3'd2, v); chk("R5 match flag", v[5], 1);

    // R7: tov has no effect in capture mode
    wr(3'd1, 3);
    wr(3'd2, 16'h03);        // capture rising, tov on
    step();
    keep = ch_out;
    repeat (10) step();
    chk("R7 capture pin holds", {ch_oe, ch_out}, {1'b0, keep});

    // R3: el 00 with msA set gives low
    wr(3'd2, 16'h08);
    step();
    chk("R3 preset low", {ch_oe, ch_out}, 2'b00);

    // constrained random, judged by the lockstep model (R4 R5 R6 R7 R9 R11)
    for (int c = 0; c < 40; c++) begin
      wr(3'd1, W'($urandom_range(15, 1)));
      wr(3'd3, W'($urandom % 16));
      wr(3'd2, W'($urandom % 32));
      for (int t = 0; t < 60; t++) begin
        automatic int r = $urandom % 100;
        if (r < 6)       begin wr_en = 1; wr_addr = 3'd2; wr_data = W'($urandom % 64); end
        else if (r < 10) begin wr_en = 1; wr_addr = 3'd3; wr_data = W'($urandom % 16); end
        else if (r < 12) begin wr_en = 1; wr_addr = 3'd0; wr_data = W'(($urandom % 8) == 0); end
        else if (r < 14) begin wr_en = 1; wr_addr = 3'd1; wr_data = W'($urandom_range(15, 1)); end
        else             wr_en = 0;
        rd_en   = ($urandom % 4) == 0;
        rd_addr = ($urandom % 2) ? 3'd2 : 3'(($urandom % 5));
        if (($urandom % 5) == 0) cap_in = ~cap_in;
        step();
      end
      wr_en = 0; rd_en = 0;
      wr(3'd0, 0);
    end

    step();
    finish_run();
  end
endmodule